// File: doc/BRIEF.md
# Compare-Match Tracking Timer

This block is a timer peripheral driven by one system clock. A single free-running prescaler divides that clock by powers of two and hands out three one-cycle strobes. With a 16 MHz clock and default parameters these are 125 kHz (divide by 128) for quadrature-decode logic, about 15.6 kHz (divide by 1024) for motor chop logic, and about 3906 Hz (divide by 4096). The slowest strobe also advances a 14-bit up-counter.

Software reaches the block through a synchronous write port with a combinational read port. Through it, software can load the counter, clear it, set a compare value and mask the match interrupt. When an increment brings the counter to the compare value, a sticky match flag is set. The interrupt output is that flag gated by the mask. Each register sits at an address: 0 is the count, 1 is the compare value, 2 is control and 3 is status. Read data is zero-extended to the bus width.

Top module: `match_timer_top`

## Requirements
- R1: `qdec_tick_o` is high for one cycle in every 2^QDEC_LOG2 cycles.
- R2: `chop_tick_o` is high for one cycle in every 2^CHOP_LOG2 cycles.
- R3: `tmr_tick_o` is high for one cycle in every 2^CNT_LOG2 cycles. Whenever it is high, the other two strobes are also high.
- R4: The counter goes up by exactly one on each clock edge at which `tmr_tick_o` is high. At every other edge it holds, unless software writes it.
- R5: The counter wraps from 0x3FFF to 0 and keeps counting.
- R6: A write to address 0 loads the counter with `wdata_i[13:0]`. Upper data bits are dropped, and a read of address 0 returns the count.
- R7: A write to address 2 with bit 1 set clears the counter to 0. Bit 1 is a strobe and always reads back as 0.
- R8: A load or clear that lands on the same edge as a count strobe wins, and no increment happens on that edge.
- R9: The match flag (address 3, bit 0) is set when an increment makes the count equal to the compare value (address 1). A load that makes the count equal to the compare value does not set it.
- R10: The match flag stays set until software writes 1 to address 3 bit 0. Writing 0 there leaves it unchanged.
- R11: `irq_o` is high exactly when the match flag is set and the mask (address 2, bit 0, 1 = masked) is clear.
- R12: After reset, the count, compare value, mask and match flag are all 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Match interrupt after masking |
| qdec_tick_o | output | 1 | Quadrature-decode strobe |
| chop_tick_o | output | 1 | Chop-clock strobe |
| tmr_tick_o | output | 1 | Counter advance strobe |

## Verification
The hardest case to reach is a software load or clear that lands on the very edge where the count strobe is high (R8). The bench first waits for a falling edge at which `tmr_tick_o` is observed high. It then raises the write strobe at once, so the write and the increment meet on the next rising edge. Wrap and match-on-wrap (R5, R9) are reached by loading values just below 0x3FFF rather than by counting there. The bench shortens the prescaler so that periods and several matches fit in a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CMP   = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_MASK_BIT  = 0;
  localparam int unsigned CTRL_CLEAR_BIT = 1;
  localparam int unsigned STAT_FLAG_BIT  = 0;
  localparam int unsigned NUM_TAPS       = 3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned QDEC_LOG2 = 7,
  parameter int unsigned CHOP_LOG2 = 10,
  parameter int unsigned CNT_LOG2  = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic qdec_tick_o,
  output logic chop_tick_o,
  output logic tmr_tick_o
);
  localparam int unsigned PRE_W = CNT_LOG2;
  localparam int unsigned TAPS [tmr_pkg::NUM_TAPS] = '{QDEC_LOG2, CHOP_LOG2, CNT_LOG2};

  logic [PRE_W-1:0] pre_q;
  logic [tmr_pkg::NUM_TAPS-1:0] tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PRE_W'(1);
  end

  // each tap strobes when its low bits are all ones
  for (genvar g = 0; g < tmr_pkg::NUM_TAPS; g++) begin : g_tap
    localparam int unsigned T = TAPS[g];
    assign tick[g] = &pre_q[T-1:0];
  end

  assign qdec_tick_o = tick[0];
  assign chop_tick_o = tick[1];
  assign tmr_tick_o  = tick[2];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_inc;
  end

  // match only on a real increment
  assign match_o = tick_i & ~load_i & ~clear_i & (cnt_inc == cmp_i);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              match_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clear_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              mask_o,
  output logic              flag_o,
  output logic              irq_o
);
  reg_addr_e        addr;
  logic [CNT_W-1:0] cmp_q;
  logic             mask_q;
  logic             flag_q;
  logic             unused_hi;

  assign addr      = reg_addr_e'(addr_i);
  assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (we_i && addr == REG_CMP)  cmp_q  <= wdata_i[CNT_W-1:0];
      if (we_i && addr == REG_CTRL) mask_q <= wdata_i[CTRL_MASK_BIT];
      // set beats clear
      if (match_i)
        flag_q <= 1'b1;
      else if (we_i && addr == REG_STAT && wdata_i[STAT_FLAG_BIT])
        flag_q <= 1'b0;
    end
  end

  assign load_o     = we_i && addr == REG_COUNT;
  assign load_val_o = wdata_i[CNT_W-1:0];
  assign clear_o    = we_i && addr == REG_CTRL && wdata_i[CTRL_CLEAR_BIT];

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      REG_COUNT: rdata_o = DATA_W'(cnt_i);
      REG_CMP:   rdata_o = DATA_W'(cmp_q);
      REG_CTRL:  rdata_o[CTRL_MASK_BIT] = mask_q;
      REG_STAT:  rdata_o[STAT_FLAG_BIT] = flag_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cmp_o  = cmp_q;
  assign mask_o = mask_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ~mask_q;
endmodule

// File: rtl/match_timer_top.sv
module match_timer_top #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned QDEC_LOG2 = 7,
  parameter int unsigned CHOP_LOG2 = 10,
  parameter int unsigned CNT_LOG2  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              qdec_tick_o,
  output logic              chop_tick_o,
  output logic              tmr_tick_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             clear;
  logic             match;
  logic             mask;
  logic             flag;

  tmr_prescaler #(
    .QDEC_LOG2(QDEC_LOG2),
    .CHOP_LOG2(CHOP_LOG2),
    .CNT_LOG2 (CNT_LOG2)
  ) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .qdec_tick_o(qdec_tick_o),
    .chop_tick_o(chop_tick_o),
    .tmr_tick_o (tmr_tick_o)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tmr_tick_o),
    .load_i    (load),
    .load_val_i(load_val),
    .clear_i   (clear),
    .cmp_i     (cmp),
    .cnt_o     (cnt),
    .match_o   (match)
  );

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .cnt_i     (cnt),
    .match_i   (match),
    .load_o    (load),
    .load_val_o(load_val),
    .clear_o   (clear),
    .cmp_o     (cmp),
    .mask_o    (mask),
    .flag_o    (flag),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              qdec_tick_o,
  input logic              chop_tick_o,
  input logic              tmr_tick_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              mask,
  input logic              flag
);
  // R3
  tick_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_tick_o |-> (chop_tick_o && qdec_tick_o));

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !tmr_tick_o) |=> $stable(cnt));

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && tmr_tick_o) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R8
  load_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> (cnt == $past(wdata_i[CNT_W-1:0])));

  // R9
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> ($past(tmr_tick_o) && cnt == $past(cmp)));

  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && !mask));
endmodule

bind match_timer_top match_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .qdec_tick_o(qdec_tick_o),
  .chop_tick_o(chop_tick_o),
  .tmr_tick_o (tmr_tick_o),
  .cnt        (cnt),
  .cmp        (cmp),
  .mask       (mask),
  .flag       (flag)
);

// File: tb/sim_match_timer_top.sv
`timescale 1ns/1ps
module sim_match_timer_top;
  localparam int unsigned CNT_W  = 14;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned QL = 3, CL = 5, TL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq, qtick, ctick, ttick;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  match_timer_top #(
    .CNT_W(CNT_W), .DATA_W(DATA_W),
    .QDEC_LOG2(QL), .CHOP_LOG2(CL), .CNT_LOG2(TL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .qdec_tick_o(qtick), .chop_tick_o(ctick), .tmr_tick_o(ttick)
  );

  typedef struct packed {
    logic [15:0] ld;
    logic [15:0] cmp;
    logic        mask;
    logic [3:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_flag;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd5,      16'd8,      1'b0, 4'd3, 16'd8,      1'b1, 1'b1}, // R9 R11
    '{16'd5,      16'd8,      1'b1, 4'd3, 16'd8,      1'b1, 1'b0}, // R11 masked
    '{16'd5,      16'd9,      1'b0, 4'd3, 16'd8,      1'b0, 1'b0}, // R4 no match
    '{16'h3FFE,   16'h0000,   1'b0, 4'd2, 16'h0000,   1'b1, 1'b1}, // R5 match on wrap
    '{16'h3FFF,   16'h3FFF,   1'b0, 4'd2, 16'h0001,   1'b0, 1'b0}, // R9 load-equal no flag
    '{16'd100,    16'd101,    1'b0, 4'd1, 16'd101,    1'b1, 1'b1}, // R4 single step
    '{16'h1234,   16'h1236,   1'b0, 4'd3, 16'h1237,   1'b1, 1'b1}  // R10 sticky past match
  };

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic sync_tick();
    @(negedge clk);
    while (ttick !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sync_tick();
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: pick = qtick;
      1: pick = ctick;
      default: pick = ttick;
    endcase
  endfunction

  task automatic period(input int sel, output int p);
    @(negedge clk);
    while (pick(sel) !== 1'b1) @(negedge clk);
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (pick(sel) !== 1'b1);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    report();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    int p;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    bus_rd(2'd0, d); chk("R12 count", d, 16'd0);
    bus_rd(2'd1, d); chk("R12 cmp",   d, 16'd0);
    bus_rd(2'd2, d); chk("R12 ctrl",  d, 16'd0);
    bus_rd(2'd3, d); chk("R12 flag",  d, 16'd0);
    chk("R12 irq", {15'd0, irq}, 16'd0);

    // R1 R2 R3 strobe periods
    period(0, p); chk("R1 qdec period", 16'(p), 16'd8);
    period(1, p); chk("R2 chop period", 16'(p), 16'd32);
    period(2, p); chk("R3 tmr period",  16'(p), 16'd64);

    // vector table
    for (int v = 0; v < NV; v++) begin
      sync_tick();
      @(posedge clk);
      bus_wr(2'd0, VECS[v].ld);
      bus_wr(2'd1, VECS[v].cmp);
      bus_wr(2'd2, {15'd0, VECS[v].mask});
      bus_wr(2'd3, 16'd1);
      wait_ticks(int'(VECS[v].n));
      bus_rd(2'd0, d); chk("R4 R5 vec count", d, VECS[v].exp_cnt);
      bus_rd(2'd3, d); chk("R9 vec flag", d, {15'd0, VECS[v].exp_flag});
      chk("R11 vec irq", {15'd0, irq}, {15'd0, VECS[v].exp_irq});
    end

    // R10 flag from last vector is set; write 0 keeps it, write 1 clears
    bus_wr(2'd3, 16'd0);
    bus_rd(2'd3, d); chk("R10 write0 keeps", d, 16'd1);
    bus_wr(2'd2, 16'd1);
    chk("R11 mask hides irq", {15'd0, irq}, 16'd0);
    bus_wr(2'd2, 16'd0);
    chk("R11 unmask shows irq", {15'd0, irq}, 16'd1);
    bus_wr(2'd3, 16'd1);
    bus_rd(2'd3, d); chk("R10 write1 clears", d, 16'd0);
    chk("R10 irq drops", {15'd0, irq}, 16'd0);

    // R6 upper bits dropped
    sync_tick();
    @(posedge clk);
    bus_wr(2'd0, 16'hFFFF);
    bus_rd(2'd0, d); chk("R6 load width", d, 16'h3FFF);

    // R7 clear
    bus_wr(2'd2, 16'h0002);
    bus_rd(2'd0, d); chk("R7 clear count", d, 16'd0);
    bus_rd(2'd2, d); chk("R7 clear reads 0", d, 16'd0);

    // R8 load on the tick edge
    sync_tick();
    addr = 2'd0; wdata = 16'd7; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    bus_rd(2'd0, d); chk("R8 load beats tick", d, 16'd7);

    // R8 clear on the tick edge
    bus_wr(2'd0, 16'd40);
    sync_tick();
    addr = 2'd2; wdata = 16'h0002; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    bus_rd(2'd0, d); chk("R8 clear beats tick", d, 16'd0);

    // R4 one more plain step after the clear
    wait_ticks(1);
    bus_rd(2'd0, d); chk("R4 step after clear", d, 16'd1);

    report();
    $finish;
  end
endmodule